// File: doc/BRIEF.md
# Floating-Point Load/Store and Move Sequencer

This block carries out the data-movement instructions of a small 32-bit core that keeps its floating-point registers in hardware. It owns a register file of 64-bit floating-point registers. It executes single and double loads and stores against a 32-bit memory bus, and bit-exact moves between the integer and floating-point register files. The core's decoder hands over an operation code, an encoding form, a register index, a raw immediate, the integer base value and the integer source value. The block then works through the bus on its own and signals completion.

A double-width access does not fit the 32-bit bus, so it runs as two back-to-back word transactions, with a separate state for the upper word. Any 32-bit value written into a 64-bit register has its upper half forced to all ones, so that a single-precision value stays NaN-boxed. The compact 16-bit encodings and the stack-relative encodings share the data paths of the full-size encodings. They differ only in how the register index and the immediate are formed, and the core passes the stack pointer in as the base value for them.

Top module: `fp_ldst_seq`

## Requirements
- R1: After reset, busy, done, int_wb_valid and mem_req are low and every floating-point register reads as zero.
- R2: Op 0 (single load) makes one read at the effective address and writes {32'hFFFFFFFF, read word} into the target register.
- R3: Op 1 (double load) makes two consecutive reads, first at the effective address A and then at A+4. The target register becomes {word at A+4, word at A}, written only when the second read completes.
- R4: Op 2 (single store) makes one write at the effective address whose data is the low 32 bits of the source register.
- R5: Op 3 (double store) makes two consecutive writes: the low 32 bits at A, then the high 32 bits at A+4.
- R6: Op 4 (integer to FP move) makes no bus request and writes {32'hFFFFFFFF, int_src} into the target register, with done one cycle after it was accepted.
- R7: Op 5 (FP to integer move) makes no bus request and, together with done, raises int_wb_valid with int_wb_data equal to the low 32 bits of the register.
- R8: Form 0 (full) uses issue_freg as the index and sign-extends the 12-bit immediate. Form 1 (compact) uses index 8 + issue_freg[2:0] and zero-extends the immediate. Forms 2 and 3 (stack) use issue_freg as the index and zero-extend the immediate. The effective address is base_val plus the extended immediate.
- R9: While mem_req is high and mem_ready is low, the request holds: mem_req, mem_we, mem_addr and mem_wdata stay unchanged.
- R10: busy is high from the cycle after an accepted issue until the final transaction or move completes. done is a one-cycle pulse with busy low. An issue presented while busy is ignored.
- R11: Ops 6 and 7 are ignored: no busy, no done, no bus request and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_valid | input | 1 | Instruction presented |
| issue_op | input | 3 | Operation code (0..5 valid) |
| issue_form | input | 2 | Encoding form: full, compact, stack |
| issue_freg | input | 5 | FP register field |
| issue_imm | input | 12 | Raw immediate, byte offset |
| base_val | input | 32 | Integer base register value |
| int_src | input | 32 | Integer source value for move |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| int_wb_valid | output | 1 | Integer writeback strobe |
| int_wb_data | output | 32 | Integer writeback value |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write enable |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data |
| mem_ready | input | 1 | Bus accepts/completes transaction |
| mem_rdata | input | 32 | Bus read data |

## Verification
On every cycle the assertions check the handshake invariants: a held request stays stable while the bus stalls, a request appears only while busy, and done is a single-cycle pulse that coincides with idle and with every integer writeback. Data content cannot be checked this way: NaN-boxing, word ordering across the two halves of a double, index and immediate extension per form, and ignored issues all show only in the bench's scenarios. These compare bus traffic and moved values against a register model built from the requirements.

// File: rtl/fp_ldst_seq.sv
module fp_ldst_seq #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int IMMW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [2:0]      issue_op,
  input  logic [1:0]      issue_form,
  input  logic [$clog2(NREG)-1:0] issue_freg,
  input  logic [IMMW-1:0] issue_imm,
  input  logic [AW-1:0]   base_val,
  input  logic [DW-1:0]   int_src,
  output logic            busy,
  output logic            done,
  output logic            int_wb_valid,
  output logic [DW-1:0]   int_wb_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int RIW = $clog2(NREG);
  localparam int FW  = 2 * DW;
  localparam logic [2:0] OP_LW = 3'd0, OP_LD = 3'd1, OP_SW = 3'd2,
                         OP_SD = 3'd3, OP_MWX = 3'd4, OP_MXW = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_MOVE} st_e;

  st_e             state_q;
  logic [2:0]      op_q;
  logic [RIW-1:0]  idx_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   src_q, lo_q, wbd_q;
  logic            done_q, wbv_q;
  logic [FW-1:0]   rf [NREG];

  logic [RIW-1:0]  eff_idx;
  logic [AW-1:0]   eff_off;
  logic            accept, is_move, is_dbl, xfer;
  logic            rf_we;
  logic [FW-1:0]   rf_wd;

  assign eff_idx = (issue_form == 2'd1) ? RIW'(8) + RIW'(issue_freg[2:0]) : issue_freg;
  assign eff_off = (issue_form == 2'd0) ? AW'($signed(issue_imm)) : AW'(issue_imm);
  assign accept  = issue_valid && (state_q == ST_IDLE) && (issue_op <= OP_MXW);
  assign is_move = (issue_op == OP_MWX) || (issue_op == OP_MXW);
  assign is_dbl  = (op_q == OP_LD) || (op_q == OP_SD);

  assign busy         = state_q != ST_IDLE;
  assign done         = done_q;
  assign int_wb_valid = wbv_q;
  assign int_wb_data  = wbd_q;
  assign mem_req      = (state_q == ST_LO) || (state_q == ST_HI);
  assign mem_we       = (op_q == OP_SW) || (op_q == OP_SD);
  assign mem_addr     = (state_q == ST_HI) ? addr_q + AW'(4) : addr_q;
  assign mem_wdata    = (state_q == ST_HI) ? rf[idx_q][FW-1:DW] : rf[idx_q][DW-1:0];
  assign xfer         = mem_req && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      src_q   <= '0;
      lo_q    <= '0;
      wbd_q   <= '0;
      done_q  <= 1'b0;
      wbv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wbv_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= issue_op;
          idx_q   <= eff_idx;
          addr_q  <= base_val + eff_off;
          src_q   <= int_src;
          state_q <= is_move ? ST_MOVE : ST_LO;
        end
        ST_LO: if (xfer) begin
          if (is_dbl) begin
            lo_q    <= mem_rdata;
            state_q <= ST_HI;
          end else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_HI: if (xfer) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          if (op_q == OP_MXW) begin
            wbv_q <= 1'b1;
            wbd_q <= rf[idx_q][DW-1:0];
          end
        end
      endcase
    end
  end

  assign rf_we = (state_q == ST_LO && xfer && op_q == OP_LW) ||
                 (state_q == ST_HI && xfer && op_q == OP_LD) ||
                 (state_q == ST_MOVE && op_q == OP_MWX);
  assign rf_wd = (op_q == OP_LD) ? {mem_rdata, lo_q} :
                 (op_q == OP_LW) ? {{DW{1'b1}}, mem_rdata} : {{DW{1'b1}}, src_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (rf_we) begin
      rf[idx_q] <= rf_wd;
    end
  end
endmodule

module fp_ldst_seq_chk #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          int_wb_valid,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
  // R10
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) int_wb_valid |-> done);
endmodule

bind fp_ldst_seq fp_ldst_seq_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .int_wb_valid(int_wb_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready)
);

// File: tb/fp_ldst_seq_tb_top.sv
module fp_ldst_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [2:0] issue_op = '0;
  logic [1:0] issue_form = '0;
  logic [4:0] issue_freg = '0;
  logic [11:0] issue_imm = '0;
  logic [31:0] base_val = '0, int_src = '0;
  logic busy, done, int_wb_valid, mem_req, mem_we;
  logic [31:0] int_wb_data, mem_addr, mem_wdata, mem_rdata;
  logic mem_ready = 1'b1;

  always #4 clk = ~clk;

  fp_ldst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_form(issue_form), .issue_freg(issue_freg), .issue_imm(issue_imm),
    .base_val(base_val), .int_src(int_src), .busy(busy), .done(done),
    .int_wb_valid(int_wb_valid), .int_wb_data(int_wb_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction
  assign mem_rdata = word_at(mem_addr);

  int checks = 0, fails = 0, cycles = 0;
  logic [63:0] model [32];
  logic [31:0] log_addr [8];
  logic [31:0] log_data [8];
  logic        log_we [8];
  int nlog = 0;

  always @(negedge clk) begin
    #1;
    if (mem_req && mem_ready && nlog < 8) begin
      log_addr[nlog] = mem_addr;
      log_data[nlog] = mem_we ? mem_wdata : mem_rdata;
      log_we[nlog]   = mem_we;
      nlog++;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL R10: watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_op(input logic [2:0] op, input logic [1:0] form, input logic [4:0] fr,
                        input logic [11:0] imm, input logic [31:0] base, input logic [31:0] src,
                        output int lat, output logic [31:0] wb, output logic wbv);
    @(negedge clk);
    nlog = 0;
    issue_op = op; issue_form = form; issue_freg = fr; issue_imm = imm;
    base_val = base; int_src = src; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    wb = int_wb_data;
    wbv = int_wb_valid;
    if (!done) check("R10 completion", 64'd0, 64'd1);
  endtask

  // op, form, freg, imm, base, src, exp_addr, exp_reg
  localparam logic [122:0] VEC [14] = '{
    {3'd4, 2'd0, 5'd5,  12'h000, 32'h0000_0000, 32'h3F80_0000, 32'h0,         5'd5},
    {3'd5, 2'd0, 5'd5,  12'h000, 32'h0000_0000, 32'h0,         32'h0,         5'd5},
    {3'd0, 2'd0, 5'd3,  12'h010, 32'h0000_1000, 32'h0,         32'h0000_1010, 5'd3},
    {3'd1, 2'd0, 5'd4,  12'hFF8, 32'h0000_2000, 32'h0,         32'h0000_1FF8, 5'd4},
    {3'd3, 2'd0, 5'd4,  12'h020, 32'h0000_3000, 32'h0,         32'h0000_3020, 5'd4},
    {3'd2, 2'd0, 5'd3,  12'h000, 32'h0000_4000, 32'h0,         32'h0000_4000, 5'd3},
    {3'd1, 2'd1, 5'd26, 12'h800, 32'h0000_0100, 32'h0,         32'h0000_0900, 5'd10},
    {3'd3, 2'd0, 5'd10, 12'h000, 32'h0000_5000, 32'h0,         32'h0000_5000, 5'd10},
    {3'd0, 2'd2, 5'd20, 12'hFFC, 32'h0000_8000, 32'h0,         32'h0000_8FFC, 5'd20},
    {3'd3, 2'd0, 5'd20, 12'h000, 32'h0000_6000, 32'h0,         32'h0000_6000, 5'd20},
    {3'd4, 2'd1, 5'd3,  12'h000, 32'h0000_0000, 32'h1234_5678, 32'h0,         5'd11},
    {3'd3, 2'd3, 5'd11, 12'h008, 32'h0000_7000, 32'h0,         32'h0000_7008, 5'd11},
    {3'd2, 2'd1, 5'd3,  12'h004, 32'h0000_7100, 32'h0,         32'h0000_7104, 5'd11},
    {3'd5, 2'd0, 5'd4,  12'h000, 32'h0000_0000, 32'h0,         32'h0,         5'd4}
  };

  initial begin
    int lat;
    logic [31:0] wb;
    logic wbv;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {63'd0, busy}, 64'd0);
    check("R1 done", {63'd0, done}, 64'd0);
    check("R1 mem_req", {63'd0, mem_req}, 64'd0);
    check("R1 wb_valid", {63'd0, int_wb_valid}, 64'd0);
    rst_n = 1'b1;
    run_op(3'd5, 2'd0, 5'd7, 12'h0, 32'h0, 32'h0, lat, wb, wbv);
    check("R1 register zero", {32'd0, wb}, 64'd0);

    for (int v = 0; v < 14; v++) begin
      logic [2:0] op; logic [1:0] fm; logic [4:0] fr, er; logic [11:0] im;
      logic [31:0] bs, sr, ea;
      {op, fm, fr, im, bs, sr, ea, er} = VEC[v];
      run_op(op, fm, fr, im, bs, sr, lat, wb, wbv);
      case (op)
        3'd0: begin // R2
          check("R2 count", 64'(nlog), 64'd1);
          check("R2 addr R8", {32'd0, log_addr[0]}, {32'd0, ea});
          check("R2 read", {63'd0, log_we[0]}, 64'd0);
          model[er] = {32'hFFFF_FFFF, word_at(ea)};
        end
        3'd1: begin // R3
          check("R3 count", 64'(nlog), 64'd2);
          check("R3 lo addr R8", {32'd0, log_addr[0]}, {32'd0, ea});
          check("R3 hi addr", {32'd0, log_addr[1]}, {32'd0, ea + 32'd4});
          model[er] = {word_at(ea + 32'd4), word_at(ea)};
        end
        3'd2: begin // R4
          check("R4 count", 64'(nlog), 64'd1);
          check("R4 addr R8", {32'd0, log_addr[0]}, {32'd0, ea});
          check("R4 write", {63'd0, log_we[0]}, 64'd1);
          check("R4 data", {32'd0, log_data[0]}, {32'd0, model[er][31:0]});
        end
        3'd3: begin // R5
          check("R5 count", 64'(nlog), 64'd2);
          check("R5 addrs R8", {log_addr[1], log_addr[0]}, {ea + 32'd4, ea});
          check("R5 data", {log_data[1], log_data[0]}, model[er]);
          check("R5 writes", {62'd0, log_we[1], log_we[0]}, 64'd3);
        end
        3'd4: begin // R6
          check("R6 no bus", 64'(nlog), 64'd0);
          check("R6 latency", 64'(lat), 64'd2);
          model[er] = {32'hFFFF_FFFF, sr};
        end
        default: begin // R7
          check("R7 no bus", 64'(nlog), 64'd0);
          check("R7 wb_valid", {63'd0, wbv}, 64'd1);
          check("R7 wb data", {32'd0, wb}, {32'd0, model[er][31:0]});
        end
      endcase
    end

    // R9 R10: stalled double store, issue while busy ignored
    @(negedge clk);
    mem_ready = 1'b0;
    nlog = 0;
    issue_op = 3'd3; issue_form = 2'd0; issue_freg = 5'd4; issue_imm = 12'h0;
    base_val = 32'h9000; issue_valid = 1'b1;
    @(negedge clk);
    issue_op = 3'd4; issue_freg = 5'd4; int_src = 32'hDEAD_BEEF;
    @(negedge clk);
    issue_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 busy during stall", {63'd0, busy}, 64'd1);
    check("R9 addr held", {32'd0, mem_addr}, 64'h9000);
    check("R9 data held", {32'd0, mem_wdata}, {32'd0, model[4][31:0]});
    mem_ready = 1'b1;
    lat = 0;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    check("R10 done not busy", {62'd0, done, busy}, 64'd2);
    @(negedge clk);
    check("R10 done one cycle", {63'd0, done}, 64'd0);
    check("R5 stalled data", {log_data[1], log_data[0]}, model[4]);
    run_op(3'd5, 2'd0, 5'd4, 12'h0, 32'h0, 32'h0, lat, wb, wbv);
    check("R10 ignored issue", {32'd0, wb}, {32'd0, model[4][31:0]});

    // R11: reserved ops
    for (int k = 6; k < 8; k++) begin
      @(negedge clk);
      issue_op = 3'(k); issue_freg = 5'd5; int_src = 32'h1111_2222; issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
      check("R11 no busy", {62'd0, busy, mem_req}, 64'd0);
      @(negedge clk);
      check("R11 no done", {63'd0, done}, 64'd0);
    end
    run_op(3'd5, 2'd0, 5'd5, 12'h0, 32'h0, 32'h0, lat, wb, wbv);
    check("R11 register unchanged", {32'd0, wb}, {32'd0, model[5][31:0]});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule